// File: doc/BRIEF.md
# Intersection Signal Sequencer with Turn Phases

This block drives the signal heads of a two-road intersection. A Moore state machine steps through a fixed cycle of through-traffic phases and adds a protected left-turn phase for either road only when a request switch for that road is active. A countdown timer is part of the block. It counts whole seconds from a tick enable whose divider is a parameter. Each phase loads it once and then waits for it to run out.

Every phase takes a single load clock and then a wait stretch. The load clock raises the timer start strobe and presents the phase length. The wait stretch shows the same lamps and holds until the timer expires. An active-low emergency input overrides the whole sequence and flashes red and yellow on both roads. When the input is released, the cycle begins again from its first phase. All lamps and timer controls are decoded from the state register alone.

Top module: `tlc_turnlane`

## Requirements
- R1: The synchronous active-high reset `rst` places the block in the load clock of the east-west green phase and clears the timer. While in that state, `tmr_start` is 1, `tmr_dur` is 4, east-west green is lit and north-south red is lit.
- R2: Each phase begins with exactly one load clock, in which `tmr_start`=1 and `tmr_dur` carries the phase length. Wait clocks follow with `tmr_start`=0, the same lamps and the same `tmr_dur`. A phase of length D seconds lasts 1 + D*TICK_DIV clocks.
- R3: The base phases are east-west green (4 s, NS red), east-west yellow (8 s, NS red) and all-red (2 s, both reds only). They run in that order. The north-south through green is never lit.
- R4: When the east-west yellow timer expires with `ew_turn_req`=1, an east-west turn green follows (10 s: EW turn-green and EW red, NS red). It is followed by an east-west turn yellow (5 s: EW turn-green and EW yellow, NS red), and then all-red. With `ew_turn_req`=0, the block goes from east-west yellow straight to all-red.
- R5: When the all-red timer expires with `ns_turn_req`=1, a north-south turn green follows (10 s: NS turn-green and NS red, EW red). It is followed by a north-south turn yellow (5 s: NS turn-green and NS yellow, EW red), and then east-west green. With `ns_turn_req`=0, the block goes from all-red straight to east-west green.
- R6: A turn request is looked at only on the clock edge where the preceding phase's timer expires. A request that is dropped before that edge produces no turn phase.
- R7: On each clock edge that samples `emg_n`=0, the block enters or stays in emergency mode. On the first emergency clock, both reds and both yellows are lit and all other lamps are dark. After that, the lamps alternate every clock between that pattern and all dark, and `tmr_start` stays 0.
- R8: The first clock edge that samples `emg_n`=1 while in emergency mode sends the block to the load clock of east-west green.
- R9: Emergency mode takes priority over every state, including a load clock. An interrupted phase is not resumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ew_turn_req | input | 1 | East-west left-turn request switch |
| ns_turn_req | input | 1 | North-south left-turn request switch |
| emg_n | input | 1 | Emergency mode request, active low |
| ns_red | output | 1 | North-south red lamp |
| ns_yel | output | 1 | North-south yellow lamp |
| ns_grn | output | 1 | North-south through green lamp |
| ns_ltg | output | 1 | North-south left-turn green lamp |
| ew_red | output | 1 | East-west red lamp |
| ew_yel | output | 1 | East-west yellow lamp |
| ew_grn | output | 1 | East-west through green lamp |
| ew_ltg | output | 1 | East-west left-turn green lamp |
| tmr_start | output | 1 | Timer load strobe, high in a load clock |
| tmr_dur | output | DUR_W | Length of the current phase in seconds |

## Verification
The sequence is tried with no turn requests, with both requests held, and with requests that toggle at random. The first shows the bare three-phase loop and its dwell lengths. The second shows that every turn phase is inserted in its place, and the third shows the two-way branch on each side. A directed pulse that is dropped before the yellow timer expires separates sampling at the expiry edge from latching the request. Emergency bursts of random length are placed both on load clocks and in the middle of waits. They confirm the on/off alternation, the priority over a load, and the restart from east-west green on release.

// File: rtl/tlc_pkg.sv
`timescale 1ns/1ps
package tlc_pkg;

  typedef enum logic [2:0] {
    PH_EWG   = 3'd0,
    PH_EWY   = 3'd1,
    PH_EWLTG = 3'd2,
    PH_EWLTY = 3'd3,
    PH_RED   = 3'd4,
    PH_NSLTG = 3'd5,
    PH_NSLTY = 3'd6
  } phase_e;

  typedef struct packed {
    logic   emg;       // emergency mode active
    logic   flash_on;  // emergency lamps lit this clock
    phase_e phase;     // major phase
    logic   load;      // timer load clock of the phase
  } ctl_t;

  typedef struct packed {
    logic red;
    logic yel;
    logic grn;
    logic ltg;
  } head_t;

  localparam ctl_t CTL_RESET = '{emg: 1'b0, flash_on: 1'b0, phase: PH_EWG, load: 1'b1};

endpackage

// File: rtl/tlc_tick.sv
`timescale 1ns/1ps
module tlc_tick #(
  parameter int TICK_DIV = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);

  generate
    if (TICK_DIV <= 1) begin : g_every_clock
      assign tick = 1'b1;
    end else begin : g_divider
      localparam int CW = $clog2(TICK_DIV);
      localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
      logic [CW-1:0] div_q;

      always_ff @(posedge clk) begin
        if (rst || restart) div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else div_q <= div_q + 1'b1;
      end

      assign tick = (div_q == LAST) && !restart;
    end
  endgenerate

endmodule

// File: rtl/tlc_timer.sv
`timescale 1ns/1ps
module tlc_timer #(
  parameter int DUR_W    = 4,
  parameter int TICK_DIV = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DUR_W-1:0] dur,
  output logic             done
);

  logic             tick;
  logic [DUR_W-1:0] remain_q;

  tlc_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .restart (start),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) remain_q <= '0;
    else if (start) remain_q <= dur;
    else if (tick && remain_q != '0) remain_q <= remain_q - 1'b1;
  end

  // Expiry is flagged on the tick that takes the count from one to zero.
  assign done = !start && ((remain_q == DUR_W'(1) && tick) || remain_q == '0);

endmodule

// File: rtl/tlc_seq.sv
`timescale 1ns/1ps
module tlc_seq
  import tlc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic emg_n,
  input  logic ew_req,
  input  logic ns_req,
  input  logic tmr_done,
  output ctl_t ctl
);

  ctl_t ctl_q, ctl_d;

  function automatic phase_e follow(input phase_e p, input logic ew, input logic ns);
    case (p)
      PH_EWG:   follow = PH_EWY;
      PH_EWY:   follow = ew ? PH_EWLTG : PH_RED;
      PH_EWLTG: follow = PH_EWLTY;
      PH_EWLTY: follow = PH_RED;
      PH_RED:   follow = ns ? PH_NSLTG : PH_EWG;
      PH_NSLTG: follow = PH_NSLTY;
      default:  follow = PH_EWG;
    endcase
  endfunction

  always_comb begin
    ctl_d = ctl_q;
    if (!emg_n) begin
      ctl_d.emg      = 1'b1;
      ctl_d.flash_on = ctl_q.emg ? !ctl_q.flash_on : 1'b1;
      ctl_d.load     = 1'b0;
    end else if (ctl_q.emg) begin
      ctl_d = CTL_RESET;
    end else if (ctl_q.load) begin
      ctl_d.load = 1'b0;
    end else if (tmr_done) begin
      ctl_d.phase = follow(ctl_q.phase, ew_req, ns_req);
      ctl_d.load  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= CTL_RESET;
    else ctl_q <= ctl_d;
  end

  assign ctl = ctl_q;

endmodule

// File: rtl/tlc_decode.sv
`timescale 1ns/1ps
module tlc_decode
  import tlc_pkg::*;
#(
  parameter int DUR_W   = 4,
  parameter int D_EWG   = 4,
  parameter int D_EWY   = 8,
  parameter int D_RED   = 2,
  parameter int D_TURNG = 10,
  parameter int D_TURNY = 5
) (
  input  ctl_t             ctl,
  output head_t            ns_head,
  output head_t            ew_head,
  output logic             start,
  output logic [DUR_W-1:0] dur
);

  localparam head_t H_RED   = '{red: 1'b1, yel: 1'b0, grn: 1'b0, ltg: 1'b0};
  localparam head_t H_YEL   = '{red: 1'b0, yel: 1'b1, grn: 1'b0, ltg: 1'b0};
  localparam head_t H_GRN   = '{red: 1'b0, yel: 1'b0, grn: 1'b1, ltg: 1'b0};
  localparam head_t H_TGRN  = '{red: 1'b1, yel: 1'b0, grn: 1'b0, ltg: 1'b1};
  localparam head_t H_TYEL  = '{red: 1'b0, yel: 1'b1, grn: 1'b0, ltg: 1'b1};
  localparam head_t H_FLASH = '{red: 1'b1, yel: 1'b1, grn: 1'b0, ltg: 1'b0};
  localparam head_t H_DARK  = '0;

  always_comb begin
    ns_head = H_RED;
    ew_head = H_RED;
    dur     = '0;
    start   = 1'b0;
    if (ctl.emg) begin
      ns_head = ctl.flash_on ? H_FLASH : H_DARK;
      ew_head = ctl.flash_on ? H_FLASH : H_DARK;
    end else begin
      start = ctl.load;
      case (ctl.phase)
        PH_EWG:   begin ew_head = H_GRN;  dur = DUR_W'(D_EWG);   end
        PH_EWY:   begin ew_head = H_YEL;  dur = DUR_W'(D_EWY);   end
        PH_EWLTG: begin ew_head = H_TGRN; dur = DUR_W'(D_TURNG); end
        PH_EWLTY: begin ew_head = H_TYEL; dur = DUR_W'(D_TURNY); end
        PH_NSLTG: begin ns_head = H_TGRN; dur = DUR_W'(D_TURNG); end
        PH_NSLTY: begin ns_head = H_TYEL; dur = DUR_W'(D_TURNY); end
        default:  begin dur = DUR_W'(D_RED); end
      endcase
    end
  end

endmodule

// File: rtl/tlc_turnlane.sv
`timescale 1ns/1ps
module tlc_turnlane
  import tlc_pkg::*;
#(
  parameter int DUR_W    = 4,
  parameter int TICK_DIV = 1,
  parameter int D_EWG    = 4,
  parameter int D_EWY    = 8,
  parameter int D_RED    = 2,
  parameter int D_TURNG  = 10,
  parameter int D_TURNY  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ew_turn_req,
  input  logic             ns_turn_req,
  input  logic             emg_n,
  output logic             ns_red,
  output logic             ns_yel,
  output logic             ns_grn,
  output logic             ns_ltg,
  output logic             ew_red,
  output logic             ew_yel,
  output logic             ew_grn,
  output logic             ew_ltg,
  output logic             tmr_start,
  output logic [DUR_W-1:0] tmr_dur
);

  ctl_t  ctl;
  head_t ns_head, ew_head;
  logic  tmr_done;

  tlc_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .emg_n    (emg_n),
    .ew_req   (ew_turn_req),
    .ns_req   (ns_turn_req),
    .tmr_done (tmr_done),
    .ctl      (ctl)
  );

  tlc_decode #(
    .DUR_W(DUR_W), .D_EWG(D_EWG), .D_EWY(D_EWY), .D_RED(D_RED),
    .D_TURNG(D_TURNG), .D_TURNY(D_TURNY)
  ) u_dec (
    .ctl     (ctl),
    .ns_head (ns_head),
    .ew_head (ew_head),
    .start   (tmr_start),
    .dur     (tmr_dur)
  );

  tlc_timer #(.DUR_W(DUR_W), .TICK_DIV(TICK_DIV)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .start (tmr_start),
    .dur   (tmr_dur),
    .done  (tmr_done)
  );

  assign {ns_red, ns_yel, ns_grn, ns_ltg} = ns_head;
  assign {ew_red, ew_yel, ew_grn, ew_ltg} = ew_head;

endmodule

// File: rtl/tlc_turnlane_chk.sv
`timescale 1ns/1ps
module tlc_turnlane_chk #(
  parameter int DUR_W = 4,
  parameter int D_EWG = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             emg_n,
  input logic             ns_red,
  input logic             ns_yel,
  input logic             ns_grn,
  input logic             ns_ltg,
  input logic             ew_red,
  input logic             ew_yel,
  input logic             ew_grn,
  input logic             ew_ltg,
  input logic             tmr_start,
  input logic [DUR_W-1:0] tmr_dur
);

  logic [7:0] lamps;
  logic       flash_lit, all_dark;
  assign lamps     = {ns_red, ns_yel, ns_grn, ns_ltg, ew_red, ew_yel, ew_grn, ew_ltg};
  assign flash_lit = (lamps == 8'b1100_1100);
  assign all_dark  = (lamps == 8'b0000_0000);

  // R1
  a_r1_reset_load: assert property (@(posedge clk)
    rst |=> (tmr_start && ew_grn && ns_red && tmr_dur == DUR_W'(D_EWG)));

  // R2
  a_r2_load_one_clock: assert property (@(posedge clk) disable iff (rst)
    tmr_start |=> !tmr_start);

  // R2
  a_r2_wait_matches_load: assert property (@(posedge clk) disable iff (rst)
    (tmr_start && emg_n) |=> ($stable(lamps) && $stable(tmr_dur)));

  // R3
  a_r3_green_exclusive: assert property (@(posedge clk) disable iff (rst)
    !ns_grn && !(ew_grn && (ew_red || ew_yel || ns_ltg)));

  // R4
  a_r4_turn_holds_cross_red: assert property (@(posedge clk) disable iff (rst)
    (ew_ltg |-> ns_red) and (ns_ltg |-> ew_red));

  // R7
  a_r7_flash_goes_dark: assert property (@(posedge clk) disable iff (rst)
    (!emg_n && flash_lit) |=> all_dark);

  // R7
  a_r7_dark_goes_lit: assert property (@(posedge clk) disable iff (rst)
    (!emg_n && all_dark) |=> flash_lit);

  // R7, R9
  a_r7_no_timer_load: assert property (@(posedge clk) disable iff (rst)
    !emg_n |=> (!tmr_start && (flash_lit || all_dark)));

  // R8
  a_r8_release_restart: assert property (@(posedge clk) disable iff (rst)
    (emg_n && (flash_lit || all_dark)) |=> (tmr_start && ew_grn));

endmodule

bind tlc_turnlane tlc_turnlane_chk #(.DUR_W(DUR_W), .D_EWG(D_EWG)) u_chk (
  .clk(clk), .rst(rst), .emg_n(emg_n),
  .ns_red(ns_red), .ns_yel(ns_yel), .ns_grn(ns_grn), .ns_ltg(ns_ltg),
  .ew_red(ew_red), .ew_yel(ew_yel), .ew_grn(ew_grn), .ew_ltg(ew_ltg),
  .tmr_start(tmr_start), .tmr_dur(tmr_dur)
);

// File: tb/sim_tlc_turnlane.sv
`timescale 1ns/1ps
module sim_tlc_turnlane;

  localparam int DW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ew_req = 1'b0;
  logic ns_req = 1'b0;
  logic emg_n = 1'b1;
  logic ns_red, ns_yel, ns_grn, ns_ltg, ew_red, ew_yel, ew_grn, ew_ltg;
  logic tmr_start;
  logic [DW-1:0] tmr_dur;

  always #2.5 clk = ~clk;

  tlc_turnlane #(.DUR_W(DW), .TICK_DIV(1)) u0 (
    .clk(clk), .rst(rst), .ew_turn_req(ew_req), .ns_turn_req(ns_req), .emg_n(emg_n),
    .ns_red(ns_red), .ns_yel(ns_yel), .ns_grn(ns_grn), .ns_ltg(ns_ltg),
    .ew_red(ew_red), .ew_yel(ew_yel), .ew_grn(ew_grn), .ew_ltg(ew_ltg),
    .tmr_start(tmr_start), .tmr_dur(tmr_dur)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  string focus = "";

  // Reference model state. Phase codes: 0 EWG, 1 EWY, 2 EW turn G, 3 EW turn Y,
  // 4 all-red, 5 NS turn G, 6 NS turn Y.
  int mph = 0;
  int mcnt = 0;
  bit mload = 0, memg = 0, mon = 0, mvalid = 0, mrel = 0;

  function automatic int ph_dur(input int p);
    case (p)
      0: return 4;
      1: return 8;
      2, 5: return 10;
      3, 6: return 5;
      default: return 2;
    endcase
  endfunction

  // {ns_red, ns_yel, ns_grn, ns_ltg, ew_red, ew_yel, ew_grn, ew_ltg}
  function automatic logic [7:0] ph_lamps(input int p);
    case (p)
      0: return 8'b1000_0010;
      1: return 8'b1000_0100;
      2: return 8'b1000_1001;
      3: return 8'b1000_0101;
      5: return 8'b1001_1000;
      6: return 8'b0101_1000;
      default: return 8'b1000_1000;
    endcase
  endfunction

  function automatic int ph_next(input int p, input bit ew, input bit ns);
    case (p)
      0: return 1;
      1: return ew ? 2 : 4;
      2: return 3;
      3: return 4;
      4: return ns ? 5 : 0;
      5: return 6;
      default: return 0;
    endcase
  endfunction

  function automatic string ph_tag(input int p);
    case (p)
      2, 3: return "R4";
      5, 6: return "R5";
      default: return "R3";
    endcase
  endfunction

  task automatic report_summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  task automatic check_now();
    logic [7:0] got_l, exp_l;
    logic       exp_s;
    logic [DW-1:0] exp_d;
    string tag;
    got_l = {ns_red, ns_yel, ns_grn, ns_ltg, ew_red, ew_yel, ew_grn, ew_ltg};
    if (memg) begin
      exp_l = mon ? 8'b1100_1100 : 8'b0000_0000;
      exp_s = 1'b0;
      exp_d = '0;
    end else begin
      exp_l = ph_lamps(mph);
      exp_s = mload;
      exp_d = DW'(ph_dur(mph));
    end
    if (focus != "") tag = focus;
    else if (memg) tag = "R7";
    else if (mrel) tag = "R8";
    else tag = ph_tag(mph);
    n_checks++;
    if (got_l !== exp_l) begin
      n_fail++;
      $display("FAIL %s: lamps got %b expected %b", tag, got_l, exp_l);
    end
    n_checks++;
    if (tmr_start !== exp_s || tmr_dur !== exp_d) begin
      n_fail++;
      $display("FAIL %s/R2: timer got start=%b dur=%0d expected start=%b dur=%0d",
               tag, tmr_start, tmr_dur, exp_s, exp_d);
    end
  endtask

  task automatic model_advance(input bit r, input bit e_n, input bit ew, input bit ns);
    if (r) begin
      mph = 0; mload = 1; memg = 0; mon = 0; mvalid = 1; mrel = 0;
    end else if (!mvalid) begin
      mvalid = 0;
    end else if (!e_n) begin
      if (memg) mon = !mon;
      else begin memg = 1; mon = 1; end
    end else if (memg) begin
      memg = 0; mph = 0; mload = 1; mrel = 1;
    end else if (mload) begin
      mload = 0; mrel = 0; mcnt = ph_dur(mph);
    end else begin
      mcnt--;
      if (mcnt == 0) begin
        mph = ph_next(mph, ew, ns);
        mload = 1;
      end
    end
  endtask

  task automatic step(input bit r, input bit e_n, input bit ew, input bit ns);
    @(negedge clk);
    if (mvalid && !finished) check_now();
    rst = r; emg_n = e_n; ew_req = ew; ns_req = ns;
    model_advance(r, e_n, ew, ns);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL R2: watchdog expired, got running expected finished");
      report_summary();
      $finish;
    end
  end

  initial begin
    bit rew, rns;
    int burst;
    void'($urandom(32'd4242));

    // R1: reset holds the east-west green load clock.
    focus = "R1";
    step(1, 1, 0, 0);
    step(1, 1, 0, 0);
    step(1, 0, 1, 1);   // emergency low during reset must not win
    step(0, 1, 0, 0);
    focus = "";

    // R3: bare loop, no requests, two full cycles.
    for (int i = 0; i < 40; i++) step(0, 1, 0, 0);

    // R4, R5: both requests held through two cycles.
    for (int i = 0; i < 110; i++) step(0, 1, 1, 1);

    // R6: request pulse inside the east-west yellow wait, dropped before expiry.
    step(1, 1, 0, 0);
    step(0, 1, 0, 0);
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0);   // EWG load + 4 waits
    step(0, 1, 0, 0);                               // EWY load
    for (int i = 0; i < 3; i++) step(0, 1, 1, 0);   // pulse
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0);   // expiry sees request low
    focus = "R6";
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0);   // must be all-red
    focus = "";
    for (int i = 0; i < 10; i++) step(0, 1, 0, 0);

    // R9: emergency arriving on a load clock, then release (R8).
    while (!mload || memg) step(0, 1, 1, 1);
    focus = "R9";
    for (int i = 0; i < 6; i++) step(0, 0, 1, 1);
    focus = "";
    for (int i = 0; i < 20; i++) step(0, 1, 1, 0);

    // R9: emergency in the middle of a turn-green wait.
    while (!(mph == 2 && !mload && mcnt < 6) || memg) step(0, 1, 1, 1);
    focus = "R9";
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0);
    focus = "";
    for (int i = 0; i < 30; i++) step(0, 1, 0, 1);

    // Random mix of requests and emergency bursts.
    rew = 0; rns = 0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(7) == 0) rew = ~rew;
      if ($urandom_range(7) == 0) rns = ~rns;
      if ($urandom_range(199) == 0) begin
        burst = $urandom_range(9, 1);
        for (int k = 0; k < burst; k++) step(0, 0, rew, rns);
      end else begin
        step(0, 1, rew, rns);
      end
    end

    @(negedge clk);
    if (!finished) begin
      finished = 1;
      report_summary();
      $finish;
    end
  end

endmodule